// File: doc/BRIEF.md
# Daisy-chain address-space configuration controller

This block places relocatable modules in a 20-bit nibble-addressed space. The space is cut into 256 pages of 4096 nibbles each. Five modules share the space: an I/O window, a RAM, and three expansion ports, named port 1, port 2 and port 3. Anything not claimed by a module decodes to ROM.

A processor sets the modules up one at a time through a chain of configure commands. The I/O window takes one command. Each of the four memory modules takes two, a size first and then a base. An identify query reports a coded value for the next slot still waiting. An unconfigure command releases one module by address. A reset command releases all of them.

Each command is a one-cycle strobe carrying a 20-bit data word. The access decoder is purely combinational. For the current access address it returns a one-hot module select and the nibble offset inside the selected module.

Top module: `addr_cfg_unit`

## Requirements
- R1: Each configure strobe fills the first unfilled slot, taken in this fixed order: I/O base, RAM size, RAM base, port-1 size, port-1 base, port-2 size, port-2 base, port-3 size, port-3 base. When all nine slots are filled, a configure strobe changes nothing.
- R2: The I/O slot stores the data word with its low 6 bits cleared. While configured, that address and the next 63 nibbles select the I/O window, ahead of every other module.
- R3: A size step stores the page mask s, which is bits 19..12 of the data word XOR 0xFF.
- R4: A base step stores the page b, which is bits 19..12 of the data word. A configured module then claims every page p with ((p XOR b) AND NOT s) == 0. A non-contiguous mask therefore leaves unclaimed holes between the claimed pages.
- R5: selOneHot always has exactly one bit set. The bit positions are 0 ROM, 1 I/O, 2 RAM, 3 port 1, 4 port 2 and 5 port 3. The priority from highest to lowest is I/O, RAM, port 2, port 1, port 3, with ROM taken when nothing else matches.
- R6: selOffset is computed as follows. For a memory module it is (address − ((b AND NOT s)·4096)) masked to the module size of (s+1)·4096 nibbles. For I/O it is address bits 5..0. For ROM it is the full address.
- R7: An unconfigure strobe tests the modules in the order I/O, RAM, port 2, port 1, port 3. A memory module matches on the data page; the I/O window matches on bits 19..6 of the data word. Only the first configured module that matches is released. Releasing a memory module clears both its size slot and its base slot, but the stored values are kept.
- R8: On the cycle after an identify strobe, idValid is 1 and idData holds a code for the first pending slot. For the I/O slot the code is the stored I/O base XOR 0x00019. For a size slot it is s·4096 XOR 0xFF003, 0xFF005, 0xFF007 or 0xFF001 (RAM, port 1, port 2, port 3). For a base slot it is b·4096 XOR 0x000F4, 0x000F6, 0x000F8 or 0x000F2 (same order). When the chain is full the code is 0.
- R9: A reset strobe, and also rst_n, releases every module and zeroes all sizes and bases. It also sets the I/O base to the out-of-range value 0x100000, so the next identify code is 0x00019.
- R10: A memory module that has its size but not yet its base is never selected, and unconfigure ignores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdConfig | input | 1 | Configure strobe |
| cmdUnconfig | input | 1 | Unconfigure strobe |
| cmdReset | input | 1 | Release-all strobe |
| cmdQuery | input | 1 | Identify strobe |
| cmdData | input | 20 | Command operand |
| accAddr | input | 20 | Access address to decode |
| selOneHot | output | 6 | One-hot module select |
| selOffset | output | 20 | Nibble offset within the selected module |
| idValid | output | 1 | Identify result valid |
| idData | output | 20 | Identify code |

## Verification
The bench builds the block with its default values: a 20-bit address, an 8-bit page number and a 6-bit I/O window. With these values it can walk the whole nine-slot chain and reach every identify constant.

The bench places the I/O window inside the RAM, lets port 2 sit inside port 1, and gives port 3 a split mask so that it leaves a hole. This brings every priority pair, mirrored offsets and a hole within reach. It also covers partial unconfigure where two modules overlap, and reconfiguring a released slot whose stored size is non-zero.

// File: rtl/addr_cfg_pkg.sv
package addr_cfg_pkg;
  localparam int ADDR_W   = 20;
  localparam int PAGE_W   = 8;
  localparam int OFF_W    = ADDR_W - PAGE_W;
  localparam int IO_W     = 6;
  localparam int NUM_MEM  = 4;                 // RAM, port 1, port 2, port 3
  localparam int NUM_SEL  = NUM_MEM + 2;       // plus ROM and I/O
  localparam int NUM_SLOT = 1 + 2 * NUM_MEM;
  localparam int SLOT_W   = $clog2(NUM_SLOT + 1);

  // release order and decode priority over memory modules
  localparam int REL_ORDER [NUM_MEM] = '{0, 2, 1, 3};
  localparam int DEC_ORDER [NUM_MEM] = '{0, 2, 1, 3};

  localparam logic [ADDR_W-1:0] ID_IO = 20'h00019;
  localparam logic [NUM_MEM-1:0][ADDR_W-1:0] ID_SIZE =
    {20'hFF001, 20'hFF007, 20'hFF005, 20'hFF003};
  localparam logic [NUM_MEM-1:0][ADDR_W-1:0] ID_BASE =
    {20'h000F2, 20'h000F8, 20'h000F6, 20'h000F4};
  localparam logic [ADDR_W:0] IO_RESET_BASE = {1'b1, {ADDR_W{1'b0}}};

  typedef struct packed {
    logic               clrAll;
    logic               wrIo;
    logic               relIo;
    logic [NUM_MEM-1:0] wrSize;
    logic [NUM_MEM-1:0] wrBase;
    logic [NUM_MEM-1:0] rel;
    logic               qry;
    logic [SLOT_W-1:0]  qrySlot;
  } cfg_strobe_t;
endpackage

// File: rtl/addr_cfg_ctrl.sv
module addr_cfg_ctrl
  import addr_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdConfig,
  input  logic               cmdUnconfig,
  input  logic               cmdReset,
  input  logic               cmdQuery,
  input  logic               ioCfg,
  input  logic [NUM_MEM-1:0] sizeCfg,
  input  logic [NUM_MEM-1:0] baseCfg,
  input  logic               matchIo,
  input  logic [NUM_MEM-1:0] matchMem,
  output cfg_strobe_t        strb,
  output logic               idValid
);
  logic [NUM_SLOT-1:0] pendVec;
  logic [SLOT_W-1:0]   pendIdx;
  logic                chainFull;
  logic                found;

  always_comb begin
    pendVec[0] = !ioCfg;
    for (int k = 0; k < NUM_MEM; k++) begin
      pendVec[2*k+1] = !sizeCfg[k];
      pendVec[2*k+2] = !baseCfg[k];
    end
  end

  always_comb begin
    pendIdx = SLOT_W'(NUM_SLOT);
    for (int i = NUM_SLOT - 1; i >= 0; i--)
      if (pendVec[i]) pendIdx = SLOT_W'(i);
  end

  assign chainFull = (pendVec == '0);

  always_comb begin
    strb         = '0;
    found        = 1'b0;
    strb.qry     = cmdQuery;
    strb.qrySlot = pendIdx;
    if (cmdReset) begin
      strb.clrAll = 1'b1;
    end else if (cmdConfig) begin
      if (!chainFull) begin
        if (pendIdx == '0) strb.wrIo = 1'b1;
        for (int k = 0; k < NUM_MEM; k++) begin
          if (pendIdx == SLOT_W'(2*k+1)) strb.wrSize[k] = 1'b1;
          if (pendIdx == SLOT_W'(2*k+2)) strb.wrBase[k] = 1'b1;
        end
      end
    end else if (cmdUnconfig) begin
      if (matchIo) begin
        strb.relIo = 1'b1;
      end else begin
        for (int j = 0; j < NUM_MEM; j++) begin
          if (!found && matchMem[REL_ORDER[j]]) begin
            strb.rel[REL_ORDER[j]] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idValid <= 1'b0;
    else        idValid <= cmdQuery;
  end

  logic [NUM_SLOT-1:0] flagVec;
  assign flagVec = {baseCfg, sizeCfg, ioCfg};

  assert_fill_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdConfig && !cmdReset && !chainFull) |=>
      ($countones(flagVec) == $countones($past(flagVec)) + 1));

  assert_full_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdConfig && !cmdReset && chainFull) |=> $stable(flagVec));

  assert_release_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdUnconfig && !cmdConfig && !cmdReset) |=>
      (($countones(flagVec) <= $countones($past(flagVec))) &&
       ($countones(flagVec) + 2 >= $countones($past(flagVec)))));
endmodule

// File: rtl/addr_cfg_regs.sv
module addr_cfg_regs
  import addr_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_strobe_t        strb,
  input  logic [ADDR_W-1:0]  cmdData,
  input  logic [ADDR_W-1:0]  accAddr,
  output logic               ioCfg,
  output logic [NUM_MEM-1:0] sizeCfg,
  output logic [NUM_MEM-1:0] baseCfg,
  output logic               matchIo,
  output logic [NUM_MEM-1:0] matchMem,
  output logic [ADDR_W-1:0]  idData,
  output logic [NUM_SEL-1:0] selOneHot,
  output logic [ADDR_W-1:0]  selOffset
);
  function automatic logic pageHit(input logic [PAGE_W-1:0] p,
                                   input logic [PAGE_W-1:0] b,
                                   input logic [PAGE_W-1:0] s);
    return ((p ^ b) & ~s) == '0;
  endfunction

  logic [ADDR_W:0]    ioBase;
  logic [PAGE_W-1:0]  sizeMask [NUM_MEM];
  logic [PAGE_W-1:0]  basePage [NUM_MEM];
  logic [NUM_MEM-1:0] memHit;
  logic [ADDR_W-1:0]  memOff [NUM_MEM];
  logic               ioHit;
  logic [PAGE_W-1:0]  cmdPage, accPage;

  assign cmdPage = cmdData[ADDR_W-1 -: PAGE_W];
  assign accPage = accAddr[ADDR_W-1 -: PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioCfg  <= 1'b0;
      ioBase <= IO_RESET_BASE;
    end else if (strb.clrAll) begin
      ioCfg  <= 1'b0;
      ioBase <= IO_RESET_BASE;
    end else if (strb.wrIo) begin
      ioCfg  <= 1'b1;
      ioBase <= {1'b0, cmdData[ADDR_W-1:IO_W], {IO_W{1'b0}}};
    end else if (strb.relIo) begin
      ioCfg  <= 1'b0;
    end
  end

  assign ioHit   = ioCfg && !ioBase[ADDR_W] &&
                   (accAddr[ADDR_W-1:IO_W] == ioBase[ADDR_W-1:IO_W]);
  assign matchIo = ioCfg && !ioBase[ADDR_W] &&
                   (cmdData[ADDR_W-1:IO_W] == ioBase[ADDR_W-1:IO_W]);

  for (genvar k = 0; k < NUM_MEM; k++) begin : g_mem
    logic              szCfg, bsCfg;
    logic [PAGE_W-1:0] mask, base, effBase;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        szCfg <= 1'b0;
        bsCfg <= 1'b0;
        mask  <= '0;
        base  <= '0;
      end else if (strb.clrAll) begin
        szCfg <= 1'b0;
        bsCfg <= 1'b0;
        mask  <= '0;
        base  <= '0;
      end else begin
        if (strb.wrSize[k]) begin
          szCfg <= 1'b1;
          mask  <= cmdPage ^ {PAGE_W{1'b1}};
        end
        if (strb.wrBase[k]) begin
          bsCfg <= 1'b1;
          base  <= cmdPage;
        end
        if (strb.rel[k]) begin
          szCfg <= 1'b0;
          bsCfg <= 1'b0;
        end
      end
    end

    assign effBase     = base & ~mask;
    assign sizeCfg[k]  = szCfg;
    assign baseCfg[k]  = bsCfg;
    assign sizeMask[k] = mask;
    assign basePage[k] = base;
    assign memHit[k]   = bsCfg && pageHit(accPage, base, mask);
    assign matchMem[k] = bsCfg && pageHit(cmdPage, base, mask);
    assign memOff[k]   = (accAddr - {effBase, {OFF_W{1'b0}}}) &
                         {mask, {OFF_W{1'b1}}};
  end

  // access decode by fixed priority
  logic taken;
  always_comb begin
    selOneHot = '0;
    selOffset = accAddr;
    taken     = ioHit;
    if (ioHit) begin
      selOneHot[1] = 1'b1;
      selOffset    = {{(ADDR_W-IO_W){1'b0}}, accAddr[IO_W-1:0]};
    end
    for (int j = 0; j < NUM_MEM; j++) begin
      if (!taken && memHit[DEC_ORDER[j]]) begin
        selOneHot[DEC_ORDER[j] + 2] = 1'b1;
        selOffset = memOff[DEC_ORDER[j]];
        taken     = 1'b1;
      end
    end
    if (!taken) selOneHot[0] = 1'b1;
  end

  // identify code for the pending slot
  logic [ADDR_W-1:0] idNext;
  always_comb begin
    idNext = '0;
    if (strb.qrySlot == '0) idNext = ioBase[ADDR_W-1:0] ^ ID_IO;
    for (int k = 0; k < NUM_MEM; k++) begin
      if (strb.qrySlot == SLOT_W'(2*k+1))
        idNext = {sizeMask[k], {OFF_W{1'b0}}} ^ ID_SIZE[k];
      if (strb.qrySlot == SLOT_W'(2*k+2))
        idNext = {basePage[k], {OFF_W{1'b0}}} ^ ID_BASE[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idData <= '0;
    else if (strb.qry) idData <= idNext;
  end

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(selOneHot) == 1);

  assert_io_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    selOneHot[1] |-> (selOffset < (1 << IO_W)));

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> (!ioCfg && sizeCfg == '0 && baseCfg == '0 &&
                     ioBase == IO_RESET_BASE));

  assert_full_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.qry && strb.qrySlot == SLOT_W'(NUM_SLOT)) |=> (idData == '0));

  assert_base_needed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (baseCfg == '0) |-> (selOneHot[NUM_SEL-1:2] == '0));
endmodule

// File: rtl/addr_cfg_unit.sv
module addr_cfg_unit
  import addr_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdConfig,
  input  logic               cmdUnconfig,
  input  logic               cmdReset,
  input  logic               cmdQuery,
  input  logic [ADDR_W-1:0]  cmdData,
  input  logic [ADDR_W-1:0]  accAddr,
  output logic [NUM_SEL-1:0] selOneHot,
  output logic [ADDR_W-1:0]  selOffset,
  output logic               idValid,
  output logic [ADDR_W-1:0]  idData
);
  cfg_strobe_t        strb;
  logic               ioCfg, matchIo;
  logic [NUM_MEM-1:0] sizeCfg, baseCfg, matchMem;

  addr_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdConfig(cmdConfig), .cmdUnconfig(cmdUnconfig),
    .cmdReset(cmdReset), .cmdQuery(cmdQuery),
    .ioCfg(ioCfg), .sizeCfg(sizeCfg), .baseCfg(baseCfg),
    .matchIo(matchIo), .matchMem(matchMem),
    .strb(strb), .idValid(idValid)
  );

  addr_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .cmdData(cmdData), .accAddr(accAddr),
    .ioCfg(ioCfg), .sizeCfg(sizeCfg), .baseCfg(baseCfg),
    .matchIo(matchIo), .matchMem(matchMem),
    .idData(idData), .selOneHot(selOneHot), .selOffset(selOffset)
  );
endmodule

// File: tb/sim_addr_cfg_unit.sv
module sim_addr_cfg_unit;
  localparam int CLK_PERIOD = 10;
  localparam int OP_CFG = 0, OP_UNCFG = 1, OP_RST = 2;
  localparam logic [5:0] S_ROM = 6'h01, S_IO = 6'h02, S_RAM = 6'h04,
                         S_P1 = 6'h08, S_P2 = 6'h10, S_P3 = 6'h20;

  // {address, expected select, expected offset}
  localparam int NLOOK = 13;
  localparam logic [45:0] LOOKS [NLOOK] = '{
    {20'h12345, S_IO,  20'h00005},
    {20'h1237F, S_IO,  20'h0003F},
    {20'h12380, S_RAM, 20'h00380},
    {20'h13ABC, S_RAM, 20'h01ABC},
    {20'h11FFF, S_ROM, 20'h11FFF},
    {20'h20010, S_P1,  20'h00010},
    {20'h2B123, S_P1,  20'h0B123},
    {20'h2C000, S_P2,  20'h00000},
    {20'h2FFFF, S_P2,  20'h03FFF},
    {20'h80007, S_P3,  20'h00007},
    {20'hC0123, S_P3,  20'h40123},
    {20'hA0000, S_ROM, 20'hA0000},
    {20'h30000, S_ROM, 20'h30000}
  };

  logic clk = 0, rst_n = 0;
  logic cmdConfig = 0, cmdUnconfig = 0, cmdReset = 0, cmdQuery = 0;
  logic [19:0] cmdData = '0, accAddr = '0;
  logic [5:0]  selOneHot;
  logic [19:0] selOffset, idData;
  logic        idValid;
  int nChecks = 0, nErrors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_cfg_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmdConfig(cmdConfig), .cmdUnconfig(cmdUnconfig),
    .cmdReset(cmdReset), .cmdQuery(cmdQuery), .cmdData(cmdData),
    .accAddr(accAddr), .selOneHot(selOneHot), .selOffset(selOffset),
    .idValid(idValid), .idData(idData)
  );

  task automatic check(input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic cmd(input int op, input logic [19:0] d);
    @(negedge clk);
    cmdData = d;
    cmdConfig = (op == OP_CFG);
    cmdUnconfig = (op == OP_UNCFG);
    cmdReset = (op == OP_RST);
    @(negedge clk);
    cmdConfig = 0; cmdUnconfig = 0; cmdReset = 0;
  endtask

  task automatic query(input string what, input logic [19:0] exp);
    @(negedge clk);
    cmdQuery = 1;
    @(negedge clk);
    cmdQuery = 0;
    check({what, " valid"}, {31'd0, idValid}, 32'd1);
    check({what, " code"}, {12'd0, idData}, {12'd0, exp});
  endtask

  task automatic look(input string what, input logic [19:0] a,
                      input logic [5:0] s, input logic [19:0] o);
    @(negedge clk);
    accAddr = a;
    #1;
    check({what, " sel"}, {26'd0, selOneHot}, {26'd0, s});
    check({what, " off"}, {12'd0, selOffset}, {12'd0, o});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state: nothing configured, ROM selected, idle id
    look("R9 reset decode", 20'h00000, S_ROM, 20'h00000);
    check("R8 idValid idle", {31'd0, idValid}, 32'd0);
    query("R9 reset id", 20'h00019);

    // R1/R2/R3/R4 chain build with id codes at each step (R8)
    cmd(OP_CFG, 20'h12345);
    query("R8 ram size id", 20'hFF003);
    cmd(OP_CFG, 20'hFE000);
    query("R8 ram base id", 20'h000F4);
    cmd(OP_CFG, 20'h13000);
    query("R8 p1 size id", 20'hFF005);
    cmd(OP_CFG, 20'hF0000);
    query("R3 p1 base id", 20'h000F6);
    cmd(OP_CFG, 20'h25000);
    cmd(OP_CFG, 20'hFC000);
    cmd(OP_CFG, 20'h2C000);
    cmd(OP_CFG, 20'hBF000);
    query("R3 p3 base id", 20'h000F2);
    cmd(OP_CFG, 20'h80000);
    query("R8 full id", 20'h00000);

    // R2 R4 R5 R6 table walk
    for (int i = 0; i < NLOOK; i++)
      look($sformatf("R5 R6 lookup %0d", i), LOOKS[i][45:26],
           LOOKS[i][25:20], LOOKS[i][19:0]);

    // R1 configure on a full chain is ignored
    cmd(OP_CFG, 20'h00000);
    look("R1 full ignore p2", 20'h2C000, S_P2, 20'h00000);
    look("R1 full ignore ram", 20'h12380, S_RAM, 20'h00380);
    query("R1 full still", 20'h00000);

    // R7 release port 2 only, port 1 overlaps but stays
    cmd(OP_UNCFG, 20'h2D000);
    look("R7 p1 uncovered", 20'h2C000, S_P1, 20'h0C000);
    look("R7 p1 kept", 20'h20010, S_P1, 20'h00010);
    query("R7 p2 size pending", 20'hFC007);
    cmd(OP_CFG, 20'hFC000);
    query("R8 p2 base pending", 20'h2C0F8);
    cmd(OP_CFG, 20'h2C000);
    look("R1 p2 back", 20'h2C000, S_P2, 20'h00000);

    // R7 release I/O window
    cmd(OP_UNCFG, 20'h12350);
    look("R7 io gone", 20'h12345, S_RAM, 20'h00345);
    query("R8 io pending", 20'h12359);

    // R7 no match releases nothing
    cmd(OP_CFG, 20'h12345);
    cmd(OP_UNCFG, 20'h50000);
    look("R7 no match io", 20'h12345, S_IO, 20'h00005);
    look("R7 no match p3", 20'hC0123, S_P3, 20'h40123);

    // R9 reset command
    cmd(OP_RST, 20'h00000);
    look("R9 after reset io", 20'h12345, S_ROM, 20'h12345);
    look("R9 after reset p2", 20'h2C000, S_ROM, 20'h2C000);
    query("R9 after reset id", 20'h00019);

    // R10 size without base
    cmd(OP_CFG, 20'h50000);
    cmd(OP_CFG, 20'hFE000);
    look("R10 size only", 20'h00000, S_ROM, 20'h00000);
    cmd(OP_UNCFG, 20'h00000);
    query("R10 uncfg ignored", 20'h000F4);
    look("R2 io new base", 20'h50010, S_IO, 20'h00010);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule